// File: doc/BRIEF.md
# Programmable Event-Counting Timer

This block is a 32-bit up-counter that advances on events from one of several selectable inputs and raises an interrupt request each time the count reaches a programmed modulus and falls back to zero. The event source can be the core clock, a power-of-two division of the core clock, or any of eleven external strobe lines. The strobe lines cover pins, breakpoint matches and cache events. Each strobe line passes through a two-flop synchroniser and a rising-edge detector, so a level held for several cycles counts once.

Software controls the timer through three word registers on a simple write-strobe/combinational-read port. The registers are the wrap limit, the live count and a control word. The control word holds a run bit, a 4-bit division exponent and a 4-bit source code. A one-cycle interrupt pulse and a sticky pending flag leave the block towards an interrupt controller.

Top module: `evt_timer`

## Requirements
- R1: Byte offset 0 holds the wrap limit, offset 4 the live count and offset 8 the control word, and all three read back what was written. In the control word, bit 0 is run, bits 7:4 are the division exponent and bits 11:8 are the source code, and every other bit reads as zero. Offset 12 reads as zero.
- R2: Reset, which is synchronous and active low, clears the control word, the interrupt pulse and the pending flag, so the timer is stopped.
- R3: While the run bit is 0, the count does not change unless software writes it.
- R4: Source code 0 adds one to the count on every clock cycle while running.
- R5: Source code 1 adds one to the count once every 2^N clock cycles, where N is the exponent (0 to 15). The first step comes 2^N cycles after the control word is written.
- R6: Source codes 2 to 12 select strobe line code-2. Each rising edge on that line adds exactly one to the count, and the other lines have no effect.
- R7: Source codes 13, 14 and 15 produce no events, so the count holds.
- R8: When the incremented count equals the wrap limit, the count becomes 0 and the interrupt output is high for the following cycle.
- R9: A wrap limit of 0 lets the count run from 0xFFFFFFFF to 0, and that step raises the interrupt.
- R10: A software write to the count takes priority over an event in the same cycle. The written value is stored and no wrap occurs in that cycle.
- R11: The pending flag is set by each wrap. It stays set across control writes that have bit 1 clear, and it is cleared by a control write with bit 1 set. Bit 1 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| ext_evt | input | 11 | Asynchronous event strobe lines for source codes 2 to 12 |
| irq | output | 1 | One-cycle interrupt request on each wrap |
| irq_pending | output | 1 | Sticky wrap flag |

## Verification
The assertions assume that the wrap limit and the source code do not change while an event is being counted. The stimulus keeps to this by changing them only through register writes made while the timer is stopped. The assertions also assume that strobe lines are either held low or pulsed with high and low phases of at least two cycles, so the synchroniser sees every edge. The bench drives each pulse high for two cycles and low for two cycles, and it keeps all lines low between scenarios. Count checks are made only after enough quiet cycles for the synchroniser latency to drain.

// File: rtl/evt_timer_pkg.sv
// Package evt_timer_pkg
// Holds the register offsets, control-word field positions and source codes
// that the timer modules and the bench agree on. It assumes a 4-bit
// byte-offset register port.
package evt_timer_pkg;
    localparam int OFF_LIMIT = 0;
    localparam int OFF_COUNT = 4;
    localparam int OFF_CTRL  = 8;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_ACK_BIT = 1;
    localparam int CTRL_EXP_LSB = 4;
    localparam int CTRL_SEL_LSB = 8;

    localparam int SEL_CORE_CLK = 0;
    localparam int SEL_DIV_CLK  = 1;
    localparam int SEL_STROBE0  = 2;
endpackage

// File: rtl/evt_edge_sync.sv
// Module evt_edge_sync
// Brings one asynchronous strobe line into the clock domain through a
// chain of flops, and then emits a one-cycle pulse for each rising edge.
// It assumes that the high and low phases each last longer than a clock cycle.
module evt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the line through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    // A rising edge is the synchronised level high while the previous level is low.
    assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/evt_prescaler.sv
// Module evt_prescaler
// Divides the core clock by 2^exp. While run is high and no restart is
// requested, it emits a one-cycle tick every 2^exp cycles. A restart or
// a stop returns the phase to zero.
// It assumes that exp changes only together with restart.
module evt_prescaler #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);
    localparam int PHASE_W = (1 << EXP_W) - 1;

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] mask;

    // Low bits that must all be set before a tick is due.
    assign mask = PHASE_W'((32'd1 << exp_sel) - 32'd1);

    // Advance the phase while running, and clear it on restart or stop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) phase_q <= '0;
        else                           phase_q <= phase_q + 1'b1;
    end

    // Raise the tick when the masked phase is at its last value.
    assign tick = run && ((phase_q & mask) == mask);

    // R5: with a divide ratio above one, ticks never come on adjacent cycles.
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && (exp_sel != '0)) |=> !tick);
endmodule

// File: rtl/evt_src_mux.sv
// Module evt_src_mux
// Chooses one event stream by source code. Code 0 is every cycle, code 1
// is the prescaler tick, and codes 2 and up are the strobe edge pulses in
// order. Codes beyond the last strobe give no events.
module evt_src_mux #(
    parameter int SEL_W   = 4,
    parameter int NUM_EXT = 11
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic               div_tick,
    input  logic [NUM_EXT-1:0] ext_rise,
    output logic               evt
);
    import evt_timer_pkg::*;

    // Decode the source code into a single event bit.
    always_comb begin
        evt = 1'b0;
        if (int'(sel) == SEL_CORE_CLK) evt = 1'b1;
        if (int'(sel) == SEL_DIV_CLK)  evt = div_tick;
        for (int i = 0; i < NUM_EXT; i++) begin
            if (int'(sel) == SEL_STROBE0 + i) evt = ext_rise[i];
        end
    end
endmodule

// File: rtl/evt_count_core.sv
// Module evt_count_core
// Holds the live count. On each event it adds one. When the sum equals the
// wrap limit, it stores zero instead and flags a wrap. The wrap flag is
// registered as the interrupt pulse. A software load wins over an event.
// It assumes that evt already includes the run gating.
module evt_count_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] limit,
    output logic [DATA_W-1:0] count,
    output logic              wrap,
    output logic              irq
);
    logic [DATA_W-1:0] sum;

    // Next count if an event is taken.
    assign sum  = count + 1'b1;
    // A wrap is an event with no load, whose sum matches the limit (a limit of 0 matches at full range).
    assign wrap = evt && !load && (sum == limit);

    // Update the count and register the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= wrap;
            if (load)     count <= load_val;
            else if (evt) count <= wrap ? '0 : sum;
        end
    end

    // R4: an event that does not reach the limit adds exactly one.
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !load && (DATA_W'(count + 1'b1) != limit)) |=>
        (count == DATA_W'($past(count) + 1'b1)));
    // R8: reaching the limit gives zero and an interrupt on the next cycle.
    a_r8_wrap_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !load && (DATA_W'(count + 1'b1) == limit)) |=>
        (count == '0 && irq));
    // R10: a load stores its value whatever the event input does.
    a_r10_load_priority: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/evt_timer.sv
// Module evt_timer
// Top of the event-counting timer. It holds the register file (wrap limit
// and control word), the strobe synchronisers, the prescaler, the source
// mux and the count core, and it drives the interrupt pulse and pending flag.
// It assumes a single-cycle write strobe and a combinational read.
module evt_timer #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int NUM_EXT     = 11,
    parameter int EXP_W       = 4,
    parameter int SEL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_EXT-1:0] ext_evt,
    output logic               irq,
    output logic               irq_pending
);
    import evt_timer_pkg::*;

    localparam int SEL_END = SEL_STROBE0 + NUM_EXT;

    logic              wr_limit, wr_count, wr_ctrl;
    logic [DATA_W-1:0] limit_q;
    logic              run_q;
    logic [EXP_W-1:0]  exp_q;
    logic [SEL_W-1:0]  sel_q;
    logic              pend_q;
    logic [NUM_EXT-1:0] ext_rise;
    logic              div_tick;
    logic              src_evt;
    logic [DATA_W-1:0] count;
    logic              wrap;
    logic [DATA_W-1:0] ctrl_view;

    // Decode the register written in this cycle.
    assign wr_limit = reg_wr && (reg_addr == ADDR_W'(OFF_LIMIT));
    assign wr_count = reg_wr && (reg_addr == ADDR_W'(OFF_COUNT));
    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));

    // Wrap-limit register.
    always_ff @(posedge clk) begin
        if (!rst_n)        limit_q <= '0;
        else if (wr_limit) limit_q <= reg_wdata;
    end

    // Control fields; reset stops the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            exp_q <= '0;
            sel_q <= '0;
        end else if (wr_ctrl) begin
            run_q <= reg_wdata[CTRL_RUN_BIT];
            exp_q <= reg_wdata[CTRL_EXP_LSB +: EXP_W];
            sel_q <= reg_wdata[CTRL_SEL_LSB +: SEL_W];
        end
    end

    // Sticky pending flag; a wrap in the same cycle wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  pend_q <= 1'b0;
        else if (wrap)                               pend_q <= 1'b1;
        else if (wr_ctrl && reg_wdata[CTRL_ACK_BIT]) pend_q <= 1'b0;
    end
    assign irq_pending = pend_q;

    // One synchroniser and edge detector per strobe line.
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_sync
        evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (ext_evt[g]),
            .rise     (ext_rise[g])
        );
    end

    evt_prescaler #(.EXP_W(EXP_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (wr_ctrl),
        .exp_sel (exp_q),
        .tick    (div_tick)
    );

    evt_src_mux #(.SEL_W(SEL_W), .NUM_EXT(NUM_EXT)) u_mux (
        .sel      (sel_q),
        .div_tick (div_tick),
        .ext_rise (ext_rise),
        .evt      (src_evt)
    );

    evt_count_core #(.DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (run_q && src_evt),
        .load     (wr_count),
        .load_val (reg_wdata),
        .limit    (limit_q),
        .count    (count),
        .wrap     (wrap),
        .irq      (irq)
    );

    // Assemble the control word view; unused bits stay zero.
    always_comb begin
        ctrl_view = '0;
        ctrl_view[CTRL_RUN_BIT] = run_q;
        ctrl_view[CTRL_EXP_LSB +: EXP_W] = exp_q;
        ctrl_view[CTRL_SEL_LSB +: SEL_W] = sel_q;
    end

    // Combinational read mux.
    always_comb begin
        if (reg_addr == ADDR_W'(OFF_LIMIT))      reg_rdata = limit_q;
        else if (reg_addr == ADDR_W'(OFF_COUNT)) reg_rdata = count;
        else if (reg_addr == ADDR_W'(OFF_CTRL))  reg_rdata = ctrl_view;
        else                                     reg_rdata = '0;
    end

    // R3: a stopped timer keeps its count unless software loads it.
    a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_count) |=> $stable(count));
    // R7: source codes past the last strobe never move the count.
    a_r7_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(sel_q) >= SEL_END) && !wr_count) |=> $stable(count));
    // R11: every interrupt pulse is accompanied by the pending flag.
    a_r11_pending_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_pending);
endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [10:0] ext_evt = 11'd0;
    logic        irq;
    logic        irq_pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_LIM = 4'd0, A_CNT = 4'd4, A_CTL = 4'd8;

    evt_timer u_evt_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_evt(ext_evt),
        .irq(irq), .irq_pending(irq_pending)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(logic [10:0] lines, int n);
        for (int i = 0; i < n; i++) begin
            ext_evt = lines; cyc(2);
            ext_evt = 11'd0; cyc(2);
        end
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(A_CTL, d);
        chk("R2 ctrl after reset", d, 32'd0);
        chk("R2 irq after reset", {31'd0, irq}, 32'd0);
        chk("R2 pending after reset", {31'd0, irq_pending}, 32'd0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(A_LIM, 32'h1234_5678);
        wr(A_CNT, 32'h9abc_def0);
        wr(A_CTL, 32'hFFFF_FFFF);
        rd(A_LIM, d); chk("R1 limit readback", d, 32'h1234_5678);
        rd(A_CNT, d); chk("R1 count readback", d, 32'h9abc_def0);
        rd(A_CTL, d); chk("R1 ctrl readback", d, 32'h0000_0FF1);
        rd(4'd12, d); chk("R1 offset 12", d, 32'd0);
        wr(A_CTL, 32'd0);
        wr(A_LIM, 32'd0);
    endtask

    task automatic t_core_clock();
        logic [31:0] d;
        wr(A_CNT, 32'd0);
        wr(A_CTL, 32'h001);
        cyc(5);
        rd(A_CNT, d); chk("R4 core clock count", d, 32'd5);
        wr(A_CTL, 32'd0);
        cyc(4);
        rd(A_CNT, d); chk("R3 stopped hold", d, 32'd6);
        pulse(11'h7FF, 2);
        rd(A_CNT, d); chk("R3 stopped ignores strobes", d, 32'd6);
    endtask

    task automatic t_divided();
        logic [31:0] d;
        wr(A_CNT, 32'd0);
        wr(A_CTL, 32'h121);
        cyc(7);
        rd(A_CNT, d); chk("R5 div4 after 7", d, 32'd1);
        cyc(1);
        rd(A_CNT, d); chk("R5 div4 after 8", d, 32'd2);
        wr(A_CTL, 32'd0);
        wr(A_CNT, 32'd0);
        wr(A_CTL, 32'h1F1);
        cyc(32767);
        rd(A_CNT, d); chk("R5 div32768 before", d, 32'd0);
        cyc(1);
        rd(A_CNT, d); chk("R5 div32768 at", d, 32'd1);
        wr(A_CTL, 32'd0);
    endtask

    task automatic t_strobes();
        logic [31:0] d;
        wr(A_CNT, 32'd0);
        wr(A_CTL, 32'h201);
        pulse(11'h002, 3);
        pulse(11'h001, 3);
        cyc(6);
        rd(A_CNT, d); chk("R6 line 0 edges only", d, 32'd3);
        wr(A_CTL, 32'd0);
        wr(A_CNT, 32'd0);
        wr(A_CTL, 32'hC01);
        pulse(11'h400, 4);
        cyc(6);
        rd(A_CNT, d); chk("R6 line 10 edges", d, 32'd4);
        wr(A_CTL, 32'd0);
    endtask

    task automatic t_undefined();
        logic [31:0] d;
        wr(A_CNT, 32'd7);
        wr(A_CTL, 32'hD01);
        pulse(11'h7FF, 3);
        cyc(6);
        rd(A_CNT, d); chk("R7 code 13 quiet", d, 32'd7);
        wr(A_CTL, 32'hF01);
        cyc(10);
        rd(A_CNT, d); chk("R7 code 15 quiet", d, 32'd7);
        wr(A_CTL, 32'd0);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(A_LIM, 32'd3);
        wr(A_CNT, 32'd0);
        wr(A_CTL, 32'h001);
        cyc(2);
        rd(A_CNT, d); chk("R8 before wrap", d, 32'd2);
        chk("R8 no irq before wrap", {31'd0, irq}, 32'd0);
        cyc(1);
        rd(A_CNT, d); chk("R8 wrapped to zero", d, 32'd0);
        chk("R8 irq high", {31'd0, irq}, 32'd1);
        cyc(1);
        rd(A_CNT, d); chk("R8 after wrap", d, 32'd1);
        chk("R8 irq one cycle", {31'd0, irq}, 32'd0);
        wr(A_CTL, 32'd0);
        chk("R11 pending kept", {31'd0, irq_pending}, 32'd1);
        wr(A_CTL, 32'h002);
        chk("R11 pending cleared", {31'd0, irq_pending}, 32'd0);
        rd(A_CTL, d); chk("R11 ack bit reads zero", d, 32'd0);
    endtask

    task automatic t_full_range();
        logic [31:0] d;
        wr(A_LIM, 32'd0);
        wr(A_CNT, 32'hFFFF_FFFE);
        wr(A_CTL, 32'h001);
        cyc(1);
        rd(A_CNT, d); chk("R9 at max", d, 32'hFFFF_FFFF);
        chk("R9 no irq at max", {31'd0, irq}, 32'd0);
        cyc(1);
        rd(A_CNT, d); chk("R9 wrapped", d, 32'd0);
        chk("R9 irq", {31'd0, irq}, 32'd1);
        wr(A_CTL, 32'h002);
    endtask

    task automatic t_load_priority();
        logic [31:0] d;
        wr(A_LIM, 32'd50);
        wr(A_CNT, 32'd0);
        wr(A_CTL, 32'h001);
        cyc(3);
        wr(A_CNT, 32'd20);
        rd(A_CNT, d); chk("R10 load wins", d, 32'd20);
        cyc(1);
        rd(A_CNT, d); chk("R10 counts after load", d, 32'd21);
        wr(A_CNT, 32'd49);
        rd(A_CNT, d); chk("R10 load below limit", d, 32'd49);
        chk("R10 no irq on load", {31'd0, irq}, 32'd0);
        cyc(1);
        rd(A_CNT, d); chk("R8 wrap after load", d, 32'd0);
        chk("R8 irq after load", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_mid_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        rd(A_CTL, d); chk("R2 ctrl after mid reset", d, 32'd0);
        chk("R2 pending after mid reset", {31'd0, irq_pending}, 32'd0);
        chk("R2 irq after mid reset", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset_state();
        t_regmap();
        t_core_clock();
        t_divided();
        t_strobes();
        t_undefined();
        t_wrap();
        t_full_range();
        t_load_priority();
        t_mid_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=timeout exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule